// File: doc/BRIEF.md
# Floating-Point Class Mask and Register Move Unit

This unit serves the integer-result side of a floating-point pipeline. Each request carries a 64-bit raw operand, a precision select and an operation code. The unit either sorts the operand into one of ten categories and returns a one-hot mask, or passes the bit pattern unchanged between the integer and floating-point register files. Neither path interprets the value arithmetically, and neither raises an exception flag.

A request is a single-cycle pulse on `req_vld`. The registered result is presented with `rsp_vld` on the next cycle. Between requests the result register keeps its last value. A single-precision operand sits in the low 32 bits of the source. Operation codes are: 0 classify, 1 floating-point to integer move, 2 integer to floating-point move, 3 reserved.

Top module: `fpcm_unit`

## Requirements
- R1: While reset is asserted, and directly after it is released, `rsp_vld` is 0 and `rsp_data` is all zeros.
- R2: `rsp_vld` is high in exactly the cycle after each cycle in which `req_vld` is high. `rsp_data` changes only in the cycle after a request.
- R3: Classify (op 0) sets mask bit 0 for negative infinity and bit 7 for positive infinity. Infinity means exponent all ones and mantissa zero.
- R4: Classify sets bit 1 for a negative normal value and bit 6 for a positive normal value. A normal value has an exponent that is neither all zeros nor all ones.
- R5: Classify sets bit 2 for a negative subnormal and bit 5 for a positive subnormal. A subnormal has exponent zero and a nonzero mantissa.
- R6: Classify sets bit 3 for negative zero and bit 4 for positive zero. Zero means exponent and mantissa both zero.
- R7: A NaN (exponent all ones, mantissa nonzero) sets bit 9 when its top mantissa bit is 1 (quiet) and bit 8 when that bit is 0 (signaling). The sign bit does not matter.
- R8: A classify result has exactly one of bits 9:0 set, and bits 63:10 are zero.
- R9: Single-precision classify (`req_dbl`=0) uses only bits 31:0 of the source. Double-precision classify uses all 64 bits, with the sign in bit 63, an 11-bit exponent and a 52-bit mantissa.
- R10: A single-precision move from floating point to integer (op 1) returns bits 31:0 of the source, with bit 31 copied into bits 63:32.
- R11: A single-precision move from integer to floating point (op 2) returns bits 31:0 of the source, with bits 63:32 cleared.
- R12: Double-precision moves in both directions return all 64 source bits unchanged.
- R13: The reserved op 3 produces a valid response with `rsp_data` all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_vld | input | 1 | Request strobe, one cycle per request |
| req_op | input | 2 | Operation: 0 classify, 1 FP to int move, 2 int to FP move, 3 reserved |
| req_dbl | input | 1 | 1 selects double precision, 0 selects single |
| req_src | input | 64 | Raw source operand |
| rsp_vld | output | 1 | Result strobe, one cycle after the request |
| rsp_data | output | 64 | Result value, held between requests |

## Verification
Every operation goes through the same single register stage, so each result is due exactly one cycle after its request. The bench drives a request on a falling edge and samples `rsp_vld` and `rsp_data` on the next falling edge, after the capturing rising edge has passed. It then drops the strobe and checks on the idle falling edge that follows that the strobe has cleared and that the data has held. Back-to-back requests check that each of two consecutive results appears in its own cycle.

// File: rtl/fpcm_pkg.sv
package fpcm_pkg;

    localparam int DATA_W  = 64;
    localparam int HALF_W  = DATA_W / 2;
    localparam int CLASS_W = 10;

    localparam int SP_EXP_W = 8;
    localparam int SP_MAN_W = 23;
    localparam int DP_EXP_W = 11;
    localparam int DP_MAN_W = 52;

    // Position of each category in the one-hot mask
    localparam int CLS_NEG_INF  = 0;
    localparam int CLS_NEG_NORM = 1;
    localparam int CLS_NEG_SUB  = 2;
    localparam int CLS_NEG_ZERO = 3;
    localparam int CLS_POS_ZERO = 4;
    localparam int CLS_POS_SUB  = 5;
    localparam int CLS_POS_NORM = 6;
    localparam int CLS_POS_INF  = 7;
    localparam int CLS_SNAN     = 8;
    localparam int CLS_QNAN     = 9;

    typedef enum logic [1:0] {
        OP_CLASS = 2'd0,
        OP_F2I   = 2'd1,
        OP_I2F   = 2'd2,
        OP_RSVD  = 2'd3
    } fpcm_op_e;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } fpcm_state_t;

endpackage

// File: rtl/fpcm_fmt_class.sv
module fpcm_fmt_class
    import fpcm_pkg::*;
#(
    parameter  int EXP_W = 8,
    parameter  int MAN_W = 23,
    localparam int VAL_W = 1 + EXP_W + MAN_W
) (
    input  logic [VAL_W-1:0]   val,
    output logic [CLASS_W-1:0] mask
);

    logic             sgn;
    logic [EXP_W-1:0] ex;
    logic [MAN_W-1:0] mn;
    logic             ex_max;
    logic             ex_nil;
    logic             mn_nil;

    assign sgn    = val[VAL_W-1];
    assign ex     = val[VAL_W-2 -: EXP_W];
    assign mn     = val[MAN_W-1:0];
    assign ex_max = &ex;
    assign ex_nil = ~|ex;
    assign mn_nil = ~|mn;

    always_comb begin
        mask = '0;
        if (ex_max) begin
            if (mn_nil)
                mask[sgn ? CLS_NEG_INF : CLS_POS_INF] = 1'b1;
            else
                mask[mn[MAN_W-1] ? CLS_QNAN : CLS_SNAN] = 1'b1;
        end else if (ex_nil) begin
            if (mn_nil)
                mask[sgn ? CLS_NEG_ZERO : CLS_POS_ZERO] = 1'b1;
            else
                mask[sgn ? CLS_NEG_SUB : CLS_POS_SUB] = 1'b1;
        end else begin
            mask[sgn ? CLS_NEG_NORM : CLS_POS_NORM] = 1'b1;
        end
    end

endmodule

// File: rtl/fpcm_move.sv
module fpcm_move
    import fpcm_pkg::*;
(
    input  fpcm_op_e          op,
    input  logic              dbl,
    input  logic [DATA_W-1:0] src,
    output logic [DATA_W-1:0] res
);

    logic [HALF_W-1:0] upper_fill;

    // Single-precision values leave the FP file sign-extended, enter it zero-extended
    assign upper_fill = (op == OP_F2I) ? {HALF_W{src[HALF_W-1]}} : '0;

    always_comb begin
        if (dbl)
            res = src;
        else
            res = {upper_fill, src[HALF_W-1:0]};
    end

endmodule

// File: rtl/fpcm_unit.sv
module fpcm_unit
    import fpcm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_vld,
    input  logic [1:0]        req_op,
    input  logic              req_dbl,
    input  logic [63:0]       req_src,
    output logic              rsp_vld,
    output logic [63:0]       rsp_data
);

    localparam int SP_W = 1 + SP_EXP_W + SP_MAN_W;
    localparam int DP_W = 1 + DP_EXP_W + DP_MAN_W;
    localparam int PAD_W = DATA_W - CLASS_W;

    fpcm_op_e           op;
    logic [CLASS_W-1:0] mask_sp;
    logic [CLASS_W-1:0] mask_dp;
    logic [DATA_W-1:0]  move_res;
    fpcm_state_t        st_d;
    fpcm_state_t        st_q;

    assign op = fpcm_op_e'(req_op);

    fpcm_fmt_class #(.EXP_W(SP_EXP_W), .MAN_W(SP_MAN_W)) i_cls_sp (
        .val  (req_src[SP_W-1:0]),
        .mask (mask_sp)
    );

    fpcm_fmt_class #(.EXP_W(DP_EXP_W), .MAN_W(DP_MAN_W)) i_cls_dp (
        .val  (req_src[DP_W-1:0]),
        .mask (mask_dp)
    );

    fpcm_move i_move (
        .op  (op),
        .dbl (req_dbl),
        .src (req_src),
        .res (move_res)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = req_vld;
        if (req_vld) begin
            unique case (op)
                OP_CLASS: st_d.data = {{PAD_W{1'b0}}, (req_dbl ? mask_dp : mask_sp)};
                OP_F2I,
                OP_I2F:   st_d.data = move_res;
                default:  st_d.data = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign rsp_vld  = st_q.vld;
    assign rsp_data = st_q.data;

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> rsp_vld) else $error("response missing"); // R2
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> !rsp_vld) else $error("spurious response"); // R2
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> $stable(rsp_data)) else $error("data changed while idle"); // R2
    AST_CLASS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_op == 2'd0) |=>
            ($countones(rsp_data[CLASS_W-1:0]) == 1 && rsp_data[DATA_W-1:CLASS_W] == '0))
        else $error("class mask not one-hot"); // R8
    AST_F2I_SIGN_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_op == 2'd1 && !req_dbl) |=>
            (rsp_data[DATA_W-1:HALF_W] == {HALF_W{rsp_data[HALF_W-1]}}))
        else $error("single move not sign-extended"); // R10
    AST_I2F_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_op == 2'd2 && !req_dbl) |=> (rsp_data[DATA_W-1:HALF_W] == '0))
        else $error("single move upper half not clear"); // R11
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_op == 2'd3) |=> (rsp_data == '0))
        else $error("reserved op returned data"); // R13

endmodule

// File: tb/test_fpcm_unit.sv
`timescale 1ns/1ps
module test_fpcm_unit;

    typedef struct packed {
        logic [3:0]  rq;
        logic [1:0]  op;
        logic        dbl;
        logic [63:0] src;
        logic [63:0] exp;
    } vec_t;

    localparam int NV = 31;
    localparam vec_t VECS [0:NV-1] = '{
        // single-precision classify
        '{4'd3,  2'd0, 1'b0, 64'h0000_0000_FF80_0000, 64'h001},  // R3
        '{4'd3,  2'd0, 1'b0, 64'h0000_0000_7F80_0000, 64'h080},  // R3
        '{4'd4,  2'd0, 1'b0, 64'h0000_0000_BF80_0000, 64'h002},  // R4
        '{4'd4,  2'd0, 1'b0, 64'h0000_0000_3F80_0000, 64'h040},  // R4
        '{4'd5,  2'd0, 1'b0, 64'h0000_0000_8000_0001, 64'h004},  // R5
        '{4'd5,  2'd0, 1'b0, 64'h0000_0000_0040_0000, 64'h020},  // R5
        '{4'd6,  2'd0, 1'b0, 64'h0000_0000_8000_0000, 64'h008},  // R6
        '{4'd6,  2'd0, 1'b0, 64'h0000_0000_0000_0000, 64'h010},  // R6
        '{4'd7,  2'd0, 1'b0, 64'h0000_0000_7FA0_0000, 64'h100},  // R7
        '{4'd7,  2'd0, 1'b0, 64'h0000_0000_FF80_0001, 64'h100},  // R7
        '{4'd7,  2'd0, 1'b0, 64'h0000_0000_7FC0_0000, 64'h200},  // R7
        '{4'd7,  2'd0, 1'b0, 64'h0000_0000_FFC0_0000, 64'h200},  // R7
        '{4'd9,  2'd0, 1'b0, 64'hFFF0_0000_3F80_0000, 64'h040},  // R9
        // double-precision classify
        '{4'd3,  2'd0, 1'b1, 64'hFFF0_0000_0000_0000, 64'h001},  // R3
        '{4'd3,  2'd0, 1'b1, 64'h7FF0_0000_0000_0000, 64'h080},  // R3
        '{4'd4,  2'd0, 1'b1, 64'h3FF0_0000_0000_0000, 64'h040},  // R4
        '{4'd4,  2'd0, 1'b1, 64'hC000_0000_0000_0000, 64'h002},  // R4
        '{4'd5,  2'd0, 1'b1, 64'h8000_0000_0000_0001, 64'h004},  // R5
        '{4'd5,  2'd0, 1'b1, 64'h000F_FFFF_FFFF_FFFF, 64'h020},  // R5
        '{4'd6,  2'd0, 1'b1, 64'h8000_0000_0000_0000, 64'h008},  // R6
        '{4'd6,  2'd0, 1'b1, 64'h0000_0000_0000_0000, 64'h010},  // R6
        '{4'd7,  2'd0, 1'b1, 64'h7FF0_0000_0000_0001, 64'h100},  // R7
        '{4'd7,  2'd0, 1'b1, 64'h7FF8_0000_0000_0000, 64'h200},  // R7
        '{4'd7,  2'd0, 1'b1, 64'hFFF8_0000_0000_0000, 64'h200},  // R7
        '{4'd9,  2'd0, 1'b1, 64'h0000_0000_7F80_0000, 64'h020},  // R9
        // moves
        '{4'd10, 2'd1, 1'b0, 64'h1234_5678_8000_0001, 64'hFFFF_FFFF_8000_0001}, // R10
        '{4'd10, 2'd1, 1'b0, 64'hFFFF_FFFF_7FFF_FFFF, 64'h0000_0000_7FFF_FFFF}, // R10
        '{4'd11, 2'd2, 1'b0, 64'hDEAD_BEEF_CAFE_F00D, 64'h0000_0000_CAFE_F00D}, // R11
        '{4'd12, 2'd1, 1'b1, 64'h8123_4567_89AB_CDEF, 64'h8123_4567_89AB_CDEF}, // R12
        '{4'd12, 2'd2, 1'b1, 64'hDEAD_BEEF_CAFE_F00D, 64'hDEAD_BEEF_CAFE_F00D}, // R12
        '{4'd13, 2'd3, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0}                     // R13
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_vld = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic        req_dbl = 1'b0;
    logic [63:0] req_src = '0;
    logic        rsp_vld;
    logic [63:0] rsp_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fpcm_unit i_fpcm_unit (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_vld  (req_vld),
        .req_op   (req_op),
        .req_dbl  (req_dbl),
        .req_src  (req_src),
        .rsp_vld  (rsp_vld),
        .rsp_data (rsp_data)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one request, then check its result one cycle later
    task automatic issue(input logic [1:0] op, input logic dbl, input logic [63:0] src,
                         input logic [63:0] exp, input string tag);
        @(negedge clk);
        req_vld = 1'b1; req_op = op; req_dbl = dbl; req_src = src;
        @(negedge clk);
        req_vld = 1'b0;
        check({tag, " strobe"}, {63'd0, rsp_vld}, 64'd1);
        check(tag, rsp_data, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] held;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 vld in reset", {63'd0, rsp_vld}, 64'd0);
        check("R1 data in reset", rsp_data, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 vld after reset", {63'd0, rsp_vld}, 64'd0);
        check("R1 data after reset", rsp_data, 64'd0);

        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].op, VECS[i].dbl, VECS[i].src, VECS[i].exp,
                  $sformatf("R%0d vector %0d", VECS[i].rq, i));
        end

        // R2: idle cycles keep data, strobe low; source changes ignored without strobe
        held = rsp_data;
        req_src = 64'h7FF0_0000_0000_0000; req_op = 2'd2; req_dbl = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check("R2 idle strobe", {63'd0, rsp_vld}, 64'd0);
            check("R2 idle hold", rsp_data, held);
        end

        // R2: back-to-back requests, each due one cycle later
        @(negedge clk);
        req_vld = 1'b1; req_op = 2'd0; req_dbl = 1'b0; req_src = 64'h0000_0000_8000_0000;
        @(negedge clk);
        check("R2 b2b first strobe", {63'd0, rsp_vld}, 64'd1);
        check("R2 b2b first data", rsp_data, 64'h008);
        req_op = 2'd1; req_dbl = 1'b0; req_src = 64'h0000_0000_F000_0000;
        @(negedge clk);
        req_vld = 1'b0;
        check("R2 b2b second strobe", {63'd0, rsp_vld}, 64'd1);
        check("R10 b2b second data", rsp_data, 64'hFFFF_FFFF_F000_0000);
        @(negedge clk);
        check("R2 b2b drop", {63'd0, rsp_vld}, 64'd0);

        // R1: reset mid-run clears result
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset again vld", {63'd0, rsp_vld}, 64'd0);
        check("R1 reset again data", rsp_data, 64'd0);
        rst_n = 1'b1;
        issue(2'd0, 1'b1, 64'h0010_0000_0000_0000, 64'h040, "R4 min double normal");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule